// File: doc/BRIEF.md
# Backing Store Pointer Write Adjuster

This block holds the pointer state that a register stack engine exposes to software through its backing store registers. The state is the top-of-stack pointer (BSP), the store pointer (BSPSTORE), the load pointer, the bit index into the NaT collection word, and the count of dirty registers not yet spilled. Software reads BSP or BSPSTORE through one read port. Software writes a new store pointer through one write port.

The store pointer can move to any 8-byte slot. A write therefore recomputes BSP so that the dirty registers keep their place above the new store pointer. Every 64th slot of the backing store holds a NaT collection word and not a register. BSP consequently moves up by the dirty count plus one further slot for each collection slot that the dirty span passes over. A small combinational divider by 63 produces that extra count. The dirty count itself comes from the surrounding engine through a separate load port. A store-pointer write never changes the dirty count.

Top module: `bsp_store_adjust`

## Requirements
- R1: After reset, BSP, BSPSTORE, the load pointer, the RNAT bit index and the dirty count all read as zero.
- R2: When the read enable is high, the read data is BSP if the select is 0 and BSPSTORE if the select is 1. When the read enable is low, the read data is zero.
- R3: A read, with either select, changes none of the pointer, index or count outputs.
- R4: A write sets BSPSTORE and the load pointer to the written value with bits 2:0 forced to zero. The new values are visible from the clock edge that samples the write strobe.
- R5: A write sets BSP bits 63:3 to W + N + floor((W[5:0] + N) / 63). Here W is written bits 63:3 and N is the dirty count held before that edge. The update appears at the same edge as in R4.
- R6: A write sets the RNAT bit index to written bits 8:3.
- R7: Written bits 2:0 have no effect on any state. Bits 2:0 of BSP, BSPSTORE and the load pointer are always zero.
- R8: A dirty-count load sets the count to the supplied 7-bit value at the next edge. A store-pointer write leaves the count unchanged.
- R9: When a dirty-count load and a store-pointer write share a cycle, the BSP computed by the write uses the count from before the load, and the count takes the loaded value.
- R10: In a cycle with no store-pointer write, BSP, BSPSTORE, the load pointer and the RNAT bit index keep their values, even when the dirty count is loaded.
- R11: The BSP sum of R5 wraps modulo 2^61 slots without disturbing bits 2:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Store-pointer write strobe |
| wr_data | input | 64 | New store-pointer value |
| dirty_we | input | 1 | Dirty-count load strobe |
| dirty_wdata | input | 7 | New dirty count |
| rd_en | input | 1 | Read enable |
| rd_sel | input | 1 | Read select: 0 for BSP, 1 for BSPSTORE |
| rd_data | output | 64 | Selected pointer, or zero when idle |
| bsp_o | output | 64 | Current BSP |
| bspstore_o | output | 64 | Current BSPSTORE |
| bsp_load_o | output | 64 | Current load pointer |
| rnat_idx_o | output | 6 | Current RNAT bit index |
| ndirty_o | output | 7 | Current dirty count |

## Verification
The checker watches the following on every cycle:
- the copy of the written slot address into BSPSTORE, the load pointer and the bit index;
- the zero low bits;
- the idle-read zero;
- the hold of all pointers when no write occurs;
- the hold of the count when no load occurs;
- BSP landing between N and N+3 slots above the new store pointer.

Only the bench's scenarios show the exact number of collection slots skipped for each position of the written slot within its 64-slot group and each dirty count. The bench sweeps all 64 positions against counts of 0, 1, 62, 63, 64, 126 and 127. The scenarios also cover wrap at the top of the address space and the ordering of a count load that shares a cycle with a write.

// File: rtl/bsp_adj_pkg.sv
package bsp_adj_pkg;
    // Slot addressing: 8-byte slots, low three address bits are always zero
    localparam int SLOT_LSB   = 3;
    // Bits of the slot number that locate a slot within a 64-slot group
    localparam int IDX_W      = 6;
    // Register slots per group; the 64th slot is the NaT collection word
    localparam int GROUP_REGS = 63;

    typedef enum logic {
        SEL_BSP   = 1'b0,
        SEL_STORE = 1'b1
    } rd_sel_e;
endpackage

// File: rtl/bsp_nat_div.sv
module bsp_nat_div #(
    parameter int SUM_MAX = 190
) (
    input  logic [$clog2(SUM_MAX+1)-1:0]                              sum_i,
    output logic [$clog2(SUM_MAX/bsp_adj_pkg::GROUP_REGS+1)-1:0]      quo_o
);
    import bsp_adj_pkg::*;

    localparam int SUM_W = $clog2(SUM_MAX + 1);
    localparam int QMAX  = SUM_MAX / GROUP_REGS;
    localparam int Q_W   = $clog2(QMAX + 1);

    // One comparator per possible quotient step; the quotient is the
    // number of thresholds the sum reaches (thermometer code).
    logic [QMAX-1:0] reach;

    for (genvar k = 0; k < QMAX; k++) begin : g_thr
        localparam int THR = GROUP_REGS * (k + 1);
        assign reach[k] = (sum_i >= SUM_W'(THR));
    end

    always_comb begin
        quo_o = '0;
        for (int i = 0; i < QMAX; i++) begin
            quo_o = quo_o + Q_W'(reach[i]);
        end
    end
endmodule

// File: rtl/bsp_ptr_calc.sv
module bsp_ptr_calc #(
    parameter int SLOT_W   = 61,
    parameter int NDIRTY_W = 7
) (
    input  logic [SLOT_W-1:0]   store_slot_i,
    input  logic [NDIRTY_W-1:0] ndirty_i,
    output logic [SLOT_W-1:0]   bsp_slot_o
);
    import bsp_adj_pkg::*;

    localparam int DIRTY_MAX = (1 << NDIRTY_W) - 1;
    localparam int SUM_MAX   = (GROUP_REGS) + DIRTY_MAX;
    localparam int SUM_W     = $clog2(SUM_MAX + 1);
    localparam int Q_W       = $clog2(SUM_MAX / GROUP_REGS + 1);

    logic [SUM_W-1:0] grp_sum;
    logic [Q_W-1:0]   skip;

    // Position inside the group plus the dirty span
    assign grp_sum = SUM_W'(store_slot_i[IDX_W-1:0]) + SUM_W'(ndirty_i);

    bsp_nat_div #(
        .SUM_MAX(SUM_MAX)
    ) div_i (
        .sum_i(grp_sum),
        .quo_o(skip)
    );

    assign bsp_slot_o = store_slot_i + SLOT_W'(ndirty_i) + SLOT_W'(skip);
endmodule

// File: rtl/bsp_store_adjust.sv
module bsp_store_adjust #(
    parameter int ADDR_W   = 64,
    parameter int NDIRTY_W = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [ADDR_W-1:0]   wr_data,
    input  logic                dirty_we,
    input  logic [NDIRTY_W-1:0] dirty_wdata,
    input  logic                rd_en,
    input  logic                rd_sel,
    output logic [ADDR_W-1:0]   rd_data,
    output logic [ADDR_W-1:0]   bsp_o,
    output logic [ADDR_W-1:0]   bspstore_o,
    output logic [ADDR_W-1:0]   bsp_load_o,
    output logic [5:0]          rnat_idx_o,
    output logic [NDIRTY_W-1:0] ndirty_o
);
    import bsp_adj_pkg::*;

    localparam int SLOT_W = ADDR_W - SLOT_LSB;

    typedef struct packed {
        logic [SLOT_W-1:0]   bsp;
        logic [SLOT_W-1:0]   store;
        logic [SLOT_W-1:0]   load;
        logic [IDX_W-1:0]    idx;
        logic [NDIRTY_W-1:0] nd;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic [SLOT_W-1:0] wr_slot;
    logic [SLOT_W-1:0] new_bsp;

    assign wr_slot = wr_data[ADDR_W-1:SLOT_LSB];

    // BSP candidate from the written slot and the count held before this edge
    bsp_ptr_calc #(
        .SLOT_W  (SLOT_W),
        .NDIRTY_W(NDIRTY_W)
    ) calc_i (
        .store_slot_i(wr_slot),
        .ndirty_i    (st_q.nd),
        .bsp_slot_o  (new_bsp)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.bsp   = new_bsp;
            st_d.store = wr_slot;
            st_d.load  = wr_slot;
            st_d.idx   = wr_slot[IDX_W-1:0];
        end
        if (dirty_we) begin
            st_d.nd = dirty_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bsp_o      = {st_q.bsp,   {SLOT_LSB{1'b0}}};
    assign bspstore_o = {st_q.store, {SLOT_LSB{1'b0}}};
    assign bsp_load_o = {st_q.load,  {SLOT_LSB{1'b0}}};
    assign rnat_idx_o = st_q.idx;
    assign ndirty_o   = st_q.nd;

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            rd_data = (rd_sel_e'(rd_sel) == SEL_STORE) ? bspstore_o : bsp_o;
        end
    end
endmodule

// File: rtl/bsp_store_adjust_chk.sv
module bsp_store_adjust_chk #(
    parameter int ADDR_W   = 64,
    parameter int NDIRTY_W = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   wr_data,
    input logic                dirty_we,
    input logic                rd_en,
    input logic [ADDR_W-1:0]   rd_data,
    input logic [ADDR_W-1:0]   bsp_o,
    input logic [ADDR_W-1:0]   bspstore_o,
    input logic [ADDR_W-1:0]   bsp_load_o,
    input logic [5:0]          rnat_idx_o,
    input logic [NDIRTY_W-1:0] ndirty_o
);
    localparam int SLOT_W = ADDR_W - 3;
    localparam int QMAX   = (63 + (1 << NDIRTY_W) - 1) / 63;

    logic [SLOT_W-1:0] gap;
    assign gap = bsp_o[ADDR_W-1:3] - bspstore_o[ADDR_W-1:3];

    // R4
    store_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bspstore_o == {$past(wr_data[ADDR_W-1:3]), 3'b000});

    // R4
    load_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> bsp_load_o == {$past(wr_data[ADDR_W-1:3]), 3'b000});

    // R6
    idx_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> rnat_idx_o == $past(wr_data[8:3]));

    // R5
    bsp_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (gap >= SLOT_W'($past(ndirty_o)))
               && (gap <= SLOT_W'($past(ndirty_o)) + SLOT_W'(QMAX)));

    // R7
    low_bits_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bsp_o[2:0] == 3'b000) && (bspstore_o[2:0] == 3'b000) && (bsp_load_o[2:0] == 3'b000));

    // R2
    idle_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == '0);

    // R10
    hold_without_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(bsp_o) && $stable(bspstore_o) && $stable(bsp_load_o) && $stable(rnat_idx_o));

    // R8
    count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dirty_we |=> $stable(ndirty_o));
endmodule

bind bsp_store_adjust bsp_store_adjust_chk #(
    .ADDR_W  (ADDR_W),
    .NDIRTY_W(NDIRTY_W)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .dirty_we  (dirty_we),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .bsp_o     (bsp_o),
    .bspstore_o(bspstore_o),
    .bsp_load_o(bsp_load_o),
    .rnat_idx_o(rnat_idx_o),
    .ndirty_o  (ndirty_o)
);

// File: tb/bsp_store_adjust_tb_top.sv
module bsp_store_adjust_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        dirty_we = 1'b0;
    logic [6:0]  dirty_wdata = '0;
    logic        rd_en = 1'b0;
    logic        rd_sel = 1'b0;
    logic [63:0] rd_data, bsp_o, bspstore_o, bsp_load_o;
    logic [5:0]  rnat_idx_o;
    logic [6:0]  ndirty_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    bsp_store_adjust dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .dirty_we(dirty_we), .dirty_wdata(dirty_wdata), .rd_en(rd_en),
        .rd_sel(rd_sel), .rd_data(rd_data), .bsp_o(bsp_o),
        .bspstore_o(bspstore_o), .bsp_load_o(bsp_load_o),
        .rnat_idx_o(rnat_idx_o), .ndirty_o(ndirty_o)
    );

    typedef struct {
        logic [63:0] bsp;
        logic [63:0] store;
        logic [63:0] load;
        logic [63:0] rd;
        logic [5:0]  idx;
        logic [6:0]  nd;
        int          tag;
    } exp_t;

    exp_t exp_q[$];
    int checks = 0;
    int failures = 0;
    bit done = 0;

    // reference state, slot form
    logic [60:0] m_bsp = '0, m_store = '0, m_load = '0;
    logic [5:0]  m_idx = '0;
    logic [6:0]  m_nd = '0;

    function automatic string req_name(int t);
        case (t)
            1: return "R1";   2: return "R2";   3: return "R3";
            4: return "R4";   5: return "R5";   6: return "R6";
            7: return "R7";   8: return "R8";   9: return "R9";
            10: return "R10"; 11: return "R11";
            default: return "R?";
        endcase
    endfunction

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Driver: applies one cycle of stimulus and queues the expected state
    task automatic do_op(input logic we, input logic [63:0] wd, input logic dwe,
                         input logic [6:0] dwd, input logic re, input logic rs, input int tag);
        exp_t e;
        int q_i;
        logic [60:0] ws;
        @(negedge clk);
        wr_en = we; wr_data = wd; dirty_we = dwe; dirty_wdata = dwd;
        rd_en = re; rd_sel = rs;
        ws = wd[63:3];
        if (we) begin
            q_i = (int'(ws[5:0]) + int'(m_nd)) / 63;
            m_bsp = ws + 61'(m_nd) + 61'(q_i);
            m_store = ws;
            m_load = ws;
            m_idx = wd[8:3];
        end
        if (dwe) m_nd = dwd;
        e.bsp = {m_bsp, 3'b000};
        e.store = {m_store, 3'b000};
        e.load = {m_load, 3'b000};
        e.idx = m_idx;
        e.nd = m_nd;
        e.rd = !re ? 64'h0 : (rs ? e.store : e.bsp);
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Monitor: compares each queued item just after the edge that produced it
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                string r;
                e = exp_q.pop_front();
                r = req_name(e.tag);
                chk(r, "bsp",      bsp_o,      e.bsp);
                chk(r, "bspstore", bspstore_o, e.store);
                chk(r, "load",     bsp_load_o, e.load);
                chk(r, "rnat_idx", 64'(rnat_idx_o), 64'(e.idx));
                chk(r, "ndirty",   64'(ndirty_o),   64'(e.nd));
                chk(r, "rd_data",  rd_data,    e.rd);
            end
        end
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int dl[7];
        dl = '{0, 1, 62, 63, 64, 126, 127};
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "bsp reset",      bsp_o,      64'h0);
        chk("R1", "bspstore reset", bspstore_o, 64'h0);
        chk("R1", "load reset",     bsp_load_o, 64'h0);
        chk("R1", "idx reset",      64'(rnat_idx_o), 64'h0);
        chk("R1", "ndirty reset",   64'(ndirty_o),   64'h0);
        rst_n = 1'b1;

        // R2 / R3: reads of both registers and an idle cycle change nothing
        do_op(1'b1, 64'h0000_0000_0001_0208, 1'b0, 7'd0, 1'b0, 1'b0, 4);
        do_op(1'b0, 64'h0, 1'b0, 7'd0, 1'b1, 1'b0, 3);
        do_op(1'b0, 64'h0, 1'b0, 7'd0, 1'b1, 1'b1, 3);
        do_op(1'b0, 64'hFFFF, 1'b0, 7'd0, 1'b0, 1'b1, 2);

        // R8 then R10: count load alone leaves pointers in place
        do_op(1'b0, 64'h0, 1'b1, 7'd5, 1'b1, 1'b0, 10);

        // R5 / R6 / R7: sweep slot position against boundary dirty counts
        for (int n = 0; n < 7; n++) begin
            do_op(1'b0, 64'h0, 1'b1, 7'(dl[n]), 1'b0, 1'b0, 8);
            for (int p = 0; p < 64; p++) begin
                logic [63:0] wd;
                wd = {55'h12_3456_789A_BCDE ^ 55'(n * 977 + p), 6'(p), 3'(p)};
                do_op(1'b1, wd, 1'b0, 7'd0, 1'b1, p[0], (p % 3 == 0) ? 7 : ((p % 3 == 1) ? 5 : 6));
            end
        end

        // R9: count load in the same cycle as a write
        do_op(1'b0, 64'h0, 1'b1, 7'd100, 1'b0, 1'b0, 8);
        do_op(1'b1, 64'h0000_0000_0000_0DF8, 1'b1, 7'd3, 1'b1, 1'b0, 9);
        do_op(1'b1, 64'h0000_0000_0000_01F8, 1'b0, 7'd0, 1'b1, 1'b0, 9);

        // R11: wrap at the top of the address space
        do_op(1'b0, 64'h0, 1'b1, 7'd127, 1'b0, 1'b0, 8);
        do_op(1'b1, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0, 7'd0, 1'b1, 1'b0, 11);
        do_op(1'b1, 64'hFFFF_FFFF_FFFF_FE07, 1'b0, 7'd0, 1'b1, 1'b1, 11);

        // R10: hold after a last idle cycle
        do_op(1'b0, 64'h1234, 1'b0, 7'd0, 1'b0, 1'b0, 10);
        do_op(1'b0, 64'h0, 1'b0, 7'd0, 1'b0, 1'b0, 10);

        while (exp_q.size() > 0) @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule